// File: doc/BRIEF.md
# Extendable Stack Pointer Unit

This block holds the stack pointer of an 8051-compatible core and turns every stack operation into an address and a memory select. The core raises a push command for pushes and calls, and a pop command for pops and returns. In the same cycle, the unit drives the stack address, a write flag and one of two selects: one for the 256-byte internal RAM and one for the on-chip XRAM. The pointer moves on the next clock edge.

After reset the pointer is 8 bits wide and wraps inside internal RAM. Setting an enable bit in a small configuration register widens the pointer to 11 bits, using three upper bits held in a separate high register. In that mode a push past 0FFh continues at 0100h, which lies in XRAM, so deep stacks can use the upper part of the 2 KB XRAM. The low pointer, the high pointer and the configuration register are reached through a byte-wide register port. Reads on that port return data in the same cycle.

Top module: `xsp_unit`

## Requirements
- R1: After reset the low pointer register (address 81h) reads 07h, the high register (address B7h) reads 00h and the configuration register (address AFh) reads 00h, so extended mode is off.
- R2: In a push cycle `stk_addr_o` equals the pointer plus one and `stk_wr_o` is 1; after the clock edge the pointer holds that incremented value, so the first push after reset accesses 008h.
- R3: In a pop cycle (push low) `stk_addr_o` equals the current pointer and `stk_wr_o` is 0; after the clock edge the pointer is one lower.
- R4: With extended mode off the pointer is 8 bits: a push at FFh accesses and moves to 00h, a pop at 00h moves to FFh, and every access selects internal RAM.
- R5: With extended mode on, a push at 0FFh accesses and moves to 100h with the XRAM select set, and a pop at 100h moves back to 0FFh.
- R6: With extended mode on, the 11-bit pointer wraps: a push at 7FFh accesses and moves to 000h, and a pop at 000h moves to 7FFh.
- R7: Writes to address 81h load all 8 bits of the low pointer. Writes to B7h in extended mode load bits 2:0 of the data as pointer bits 10:8. Reads of B7h return those bits in positions 2:0, with bits 7:3 zero.
- R8: With extended mode off, reads of B7h return 00h, writes to B7h leave the high bits unchanged (seen by reading them back after enabling), and the high bits take no part in the stack address.
- R9: Bit 7 of the configuration register at AFh is the extended-mode enable. Its other bits read as 0 whatever is written.
- R10: During an access, an address below 100h sets `iram_sel_o` and an address of 100h or above sets `xram_sel_o`. Exactly one select is high per access, and both are low when no access takes place.
- R11: A register write cancels a push or pop in the same cycle: no select is raised and only the written register changes. When push and pop are both high, the push is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push/call command, pre-increment |
| pop_i | input | 1 | Pop/return command, post-decrement |
| reg_we_i | input | 1 | Register port write strobe |
| reg_addr_i | input | 8 | Register port address (read and write) |
| reg_wdata_i | input | 8 | Register port write data |
| reg_rdata_o | output | 8 | Register port read data for `reg_addr_i` |
| stk_addr_o | output | 11 | Stack access address |
| stk_wr_o | output | 1 | 1 when the access is a stack write (push) |
| iram_sel_o | output | 1 | Access targets internal RAM |
| xram_sel_o | output | 1 | Access targets XRAM |

## Verification
The bench builds the unit with its default parameters: an 8-bit low pointer, 3 extra high bits, a reset value of 07h and register addresses 81h, B7h and AFh. At these widths, every wrap point can be reached in a few register writes and pushes: FFh to 00h in 8-bit mode, 0FFh to 100h across the RAM/XRAM border, and 7FFh to 000h at the top of the 11-bit range. Preloading the pointer with nearby values before each push or pop makes this possible. The same short runs also cover turning the mode on and off while stale high bits are present, and collisions between register writes and stack commands.

// File: rtl/xsp_pkg.sv
package xsp_pkg;

    localparam int SP_LO_W   = 8;
    localparam int SP_HI_W   = 3;
    localparam int SP_PTR_W  = SP_LO_W + SP_HI_W;
    localparam int SP_DATA_W = 8;

    typedef struct packed {
        logic               ext_en;
        logic [SP_HI_W-1:0] hi;
        logic [SP_LO_W-1:0] lo;
    } xsp_state_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_REGW = 2'd3
    } xsp_op_e;

endpackage

// File: rtl/xsp_stepper.sv
module xsp_stepper
    import xsp_pkg::*;
(
    input  logic [SP_PTR_W-1:0] ptr_i,
    input  logic                ext_en_i,
    input  logic                up_i,
    output logic [SP_PTR_W-1:0] ptr_o
);
    localparam int HI_W = SP_PTR_W - SP_LO_W;

    logic [SP_PTR_W-1:0] wide_step;
    logic [SP_LO_W-1:0]  narrow_step;

    always_comb begin
        wide_step   = up_i ? ptr_i + SP_PTR_W'(1) : ptr_i - SP_PTR_W'(1);
        narrow_step = up_i ? ptr_i[SP_LO_W-1:0] + SP_LO_W'(1)
                           : ptr_i[SP_LO_W-1:0] - SP_LO_W'(1);
        if (ext_en_i) begin
            ptr_o = wide_step;
        end else begin
            ptr_o = {{HI_W{1'b0}}, narrow_step};
        end
    end

endmodule

// File: rtl/xsp_regif.sv
module xsp_regif
    import xsp_pkg::*;
#(
    parameter logic [SP_DATA_W-1:0] ADDR_LO    = 8'h81,
    parameter logic [SP_DATA_W-1:0] ADDR_HI    = 8'hB7,
    parameter logic [SP_DATA_W-1:0] ADDR_CFG   = 8'hAF,
    parameter int                   CFG_EN_BIT = 7
) (
    input  logic [SP_DATA_W-1:0] addr_i,
    input  xsp_state_t           st_i,
    output logic                 hit_lo_o,
    output logic                 hit_hi_o,
    output logic                 hit_cfg_o,
    output logic [SP_DATA_W-1:0] rdata_o
);
    localparam int PAD_W = SP_DATA_W - SP_HI_W;

    always_comb begin
        hit_lo_o  = (addr_i == ADDR_LO);
        hit_hi_o  = (addr_i == ADDR_HI);
        hit_cfg_o = (addr_i == ADDR_CFG);
        rdata_o   = '0;
        if (hit_lo_o) begin
            rdata_o = st_i.lo;
        end else if (hit_hi_o) begin
            rdata_o = st_i.ext_en ? {{PAD_W{1'b0}}, st_i.hi} : '0;
        end else if (hit_cfg_o) begin
            rdata_o[CFG_EN_BIT] = st_i.ext_en;
        end
    end

endmodule

// File: rtl/xsp_router.sv
module xsp_router
    import xsp_pkg::*;
(
    input  logic                valid_i,
    input  logic [SP_PTR_W-1:0] addr_i,
    output logic                iram_sel_o,
    output logic                xram_sel_o
);
    logic upper_zero;

    always_comb begin
        upper_zero = (addr_i[SP_PTR_W-1:SP_LO_W] == '0);
        iram_sel_o = valid_i && upper_zero;
        xram_sel_o = valid_i && !upper_zero;
    end

endmodule

// File: rtl/xsp_unit.sv
module xsp_unit
    import xsp_pkg::*;
#(
    parameter logic [SP_LO_W-1:0]   RST_LO     = 8'h07,
    parameter logic [SP_DATA_W-1:0] ADDR_LO    = 8'h81,
    parameter logic [SP_DATA_W-1:0] ADDR_HI    = 8'hB7,
    parameter logic [SP_DATA_W-1:0] ADDR_CFG   = 8'hAF,
    parameter int                   CFG_EN_BIT = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_i,
    input  logic                 pop_i,
    input  logic                 reg_we_i,
    input  logic [SP_DATA_W-1:0] reg_addr_i,
    input  logic [SP_DATA_W-1:0] reg_wdata_i,
    output logic [SP_DATA_W-1:0] reg_rdata_o,
    output logic [SP_PTR_W-1:0]  stk_addr_o,
    output logic                 stk_wr_o,
    output logic                 iram_sel_o,
    output logic                 xram_sel_o
);
    localparam logic [SP_PTR_W-1:0] BORDER = SP_PTR_W'(1) << SP_LO_W;
    localparam logic [SP_LO_W-1:0]  LO_MAX = '1;

    xsp_state_t          st_q, st_d;
    xsp_op_e             op;
    logic [SP_PTR_W-1:0] ptr_eff;
    logic [SP_PTR_W-1:0] ptr_step;
    logic                hit_lo, hit_hi, hit_cfg;
    logic                acc_valid;

    always_comb begin
        if (reg_we_i)    op = OP_REGW;
        else if (push_i) op = OP_PUSH;
        else if (pop_i)  op = OP_POP;
        else             op = OP_IDLE;
        ptr_eff = {st_q.ext_en ? st_q.hi : {SP_HI_W{1'b0}}, st_q.lo};
    end

    xsp_stepper i_stepper (
        .ptr_i    (ptr_eff),
        .ext_en_i (st_q.ext_en),
        .up_i     (op == OP_PUSH),
        .ptr_o    (ptr_step)
    );

    xsp_regif #(
        .ADDR_LO    (ADDR_LO),
        .ADDR_HI    (ADDR_HI),
        .ADDR_CFG   (ADDR_CFG),
        .CFG_EN_BIT (CFG_EN_BIT)
    ) i_regif (
        .addr_i    (reg_addr_i),
        .st_i      (st_q),
        .hit_lo_o  (hit_lo),
        .hit_hi_o  (hit_hi),
        .hit_cfg_o (hit_cfg),
        .rdata_o   (reg_rdata_o)
    );

    always_comb begin
        st_d       = st_q;
        acc_valid  = (op == OP_PUSH) || (op == OP_POP);
        stk_wr_o   = (op == OP_PUSH);
        stk_addr_o = (op == OP_PUSH) ? ptr_step : ptr_eff;
        case (op)
            OP_REGW: begin
                if (hit_lo) st_d.lo = reg_wdata_i[SP_LO_W-1:0];
                if (hit_hi && st_q.ext_en) st_d.hi = reg_wdata_i[SP_HI_W-1:0];
                if (hit_cfg) st_d.ext_en = reg_wdata_i[CFG_EN_BIT];
            end
            OP_PUSH, OP_POP: begin
                st_d.lo = ptr_step[SP_LO_W-1:0];
                st_d.hi = ptr_step[SP_PTR_W-1:SP_LO_W];
            end
            default: ;
        endcase
    end

    xsp_router i_router (
        .valid_i    (acc_valid),
        .addr_i     (stk_addr_o),
        .iram_sel_o (iram_sel_o),
        .xram_sel_o (xram_sel_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ext_en <= 1'b0;
            st_q.hi     <= '0;
            st_q.lo     <= RST_LO;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !reg_we_i && st_q.ext_en) |=> (ptr_eff == $past(ptr_eff) + SP_PTR_W'(1))); // R2

    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !reg_we_i && st_q.ext_en) |=> (ptr_eff == $past(ptr_eff) - SP_PTR_W'(1))); // R3

    AST_NARROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !reg_we_i && !st_q.ext_en && st_q.lo == LO_MAX) |=> (st_q.lo == '0 && st_q.hi == '0)); // R4

    AST_NARROW_IRAM: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ext_en |-> !xram_sel_o); // R4

    AST_HI_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == ADDR_HI && !st_q.ext_en) |=> $stable(st_q.hi)); // R8

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({iram_sel_o, xram_sel_o})); // R10

    AST_XRAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        xram_sel_o |-> (stk_addr_o >= BORDER)); // R10

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_i |-> (!iram_sel_o && !xram_sel_o)); // R11

endmodule

// File: tb/test_xsp_unit.sv
module test_xsp_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [7:0]  reg_addr_i = 8'h00;
    logic [7:0]  reg_wdata_i = 8'h00;
    logic [7:0]  reg_rdata_o;
    logic [10:0] stk_addr_o;
    logic        stk_wr_o;
    logic        iram_sel_o;
    logic        xram_sel_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_lo, m_hi, m_ext;

    always #10 clk = ~clk;

    xsp_unit i_xsp_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .stk_addr_o  (stk_addr_o),
        .stk_wr_o    (stk_wr_o),
        .iram_sel_o  (iram_sel_o),
        .xram_sel_o  (xram_sel_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare against the model, then
    // let the rising edge move both the design and the model.
    task automatic step(input bit pu, input bit po, input bit we,
                        input int addr, input int wd, input string tag);
        int modulus, eff, nxt, exp_rd, exp_addr;
        bit acc;
        @(negedge clk);
        push_i = pu; pop_i = po; reg_we_i = we;
        reg_addr_i = 8'(addr); reg_wdata_i = 8'(wd);
        #2;
        modulus = m_ext ? 2048 : 256;
        eff = m_ext ? (m_hi * 256 + m_lo) : m_lo;
        if (addr == 'h81)      exp_rd = m_lo;
        else if (addr == 'hB7) exp_rd = m_ext ? m_hi : 0;
        else if (addr == 'hAF) exp_rd = m_ext * 128;
        else                   exp_rd = 0;
        check(tag, "rdata", int'(reg_rdata_o), exp_rd);
        acc = (pu || po) && !we;
        if (pu) nxt = (eff + 1) % modulus;
        else    nxt = (eff + modulus - 1) % modulus;
        exp_addr = pu ? nxt : eff;
        check(tag, "iram_sel", int'(iram_sel_o), (acc && exp_addr < 256) ? 1 : 0);
        check(tag, "xram_sel", int'(xram_sel_o), (acc && exp_addr >= 256) ? 1 : 0);
        if (acc) begin
            check(tag, "stk_addr", int'(stk_addr_o), exp_addr);
            check(tag, "stk_wr", int'(stk_wr_o), pu ? 1 : 0);
        end
        @(posedge clk);
        if (we) begin
            if (addr == 'h81) m_lo = wd % 256;
            if (addr == 'hB7 && m_ext != 0) m_hi = wd % 8;
            if (addr == 'hAF) m_ext = (wd / 128) % 2;
        end else if (pu || po) begin
            m_lo = nxt % 256;
            m_hi = nxt / 256;
        end
    endtask

    task automatic rd(input int addr, input string tag);
        step(1'b0, 1'b0, 1'b0, addr, 0, tag);
    endtask

    task automatic wr(input int addr, input int wd, input string tag);
        step(1'b0, 1'b0, 1'b1, addr, wd, tag);
    endtask

    initial begin
        m_lo = 7; m_hi = 0; m_ext = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd('h81, "R1"); rd('hB7, "R1"); rd('hAF, "R1");

        // R2 / R3 push and pop in 8-bit mode
        step(1, 0, 0, 'h81, 0, "R2");
        step(1, 0, 0, 'h81, 0, "R2");
        step(1, 0, 0, 'h81, 0, "R2");
        step(0, 1, 0, 'h81, 0, "R3");
        step(0, 1, 0, 'h81, 0, "R3");
        rd('h81, "R3");

        // R4 8-bit wrap both ways
        wr('h81, 'hFE, "R7");
        step(1, 0, 0, 'h81, 0, "R4");
        step(1, 0, 0, 'h81, 0, "R4");
        step(0, 1, 0, 'h81, 0, "R4");
        rd('h81, "R4");

        // R8 high register locked while disabled, R9 enable bit
        wr('hB7, 'h05, "R8");
        rd('hB7, "R8");
        wr('hAF, 'hFF, "R9");
        rd('hAF, "R9");
        rd('hB7, "R8");

        // R5 crossing into XRAM and back
        wr('h81, 'hFE, "R7");
        step(1, 0, 0, 'hB7, 0, "R5");
        step(1, 0, 0, 'hB7, 0, "R5");
        rd('hB7, "R5");
        step(0, 1, 0, 'h81, 0, "R5");
        step(0, 1, 0, 'h81, 0, "R5");

        // R7 high register field, R6 11-bit wrap
        wr('hB7, 'hFF, "R7");
        rd('hB7, "R7");
        wr('h81, 'hFE, "R7");
        step(1, 0, 0, 'hB7, 0, "R6");
        step(1, 0, 0, 'hB7, 0, "R6");
        rd('hB7, "R6");
        step(0, 1, 0, 'hB7, 0, "R6");
        rd('h81, "R6");

        // R10 XRAM mid-range pops
        wr('hB7, 'h03, "R7");
        wr('h81, 'h10, "R7");
        step(0, 1, 0, 'h81, 0, "R10");
        step(1, 0, 0, 'h81, 0, "R10");

        // R11 collisions
        step(1, 1, 0, 'h81, 0, "R11");
        step(1, 0, 1, 'h81, 'h40, "R11");
        step(0, 1, 1, 'hB7, 'h01, "R11");
        rd('hB7, "R11");
        rd('h81, "R11");
        step(0, 0, 0, 'h00, 0, "R11");

        // R8 disabling with stale high bits: addresses stay in internal RAM
        wr('hAF, 'h7F, "R9");
        rd('hB7, "R8");
        step(1, 0, 0, 'hB7, 0, "R8");
        step(0, 1, 0, 'h81, 0, "R8");
        wr('hAF, 'h80, "R9");
        rd('hB7, "R8");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule